// File: doc/BRIEF.md
# PTP Frame Classifier for a Transmit Stream

This block sits inline in a transmit byte stream that uses valid/ready handshaking and start/end-of-packet framing. Every beat passes through unchanged. The block looks at the leading bytes of each frame and decides whether the frame carries a precision-time-protocol message. Three carriers are recognised: directly over Ethernet, inside IPv4 UDP, and inside IPv6 UDP. For a recognised frame it works out where the downstream timestamp-insertion stage has to act.

Each frame is held in a short collapsing pipeline until enough of its header is inside. The classification is then driven combinationally, beside the first output beat of that frame, as control flags and 16-bit byte offsets counted from the frame's first byte. Per-frame sideband values travel with the frame and come out on that same first beat. These are the timestamp request and its fingerprint, the 96-bit and 64-bit ingress timestamps, and a format bit. Backpressure on the output stalls the whole pipeline.

Top module: `ptp_frame_classifier`

## Requirements
- R1: Every accepted beat leaves in arrival order, with data, start, end, empty count and error bit unchanged. No beat is dropped or duplicated. Byte 0 of a beat occupies data bits [8*BPB-1 -: 8], and the empty count gives the number of unused bytes at the low end of the end beat.
- R2: While `out_valid` is high and `out_ready` is low, the presented beat is held unchanged in the next cycle. Once every stage is occupied and the head cannot leave, `in_ready` goes low.
- R3: The values of `in_req`, `in_fp`, `in_ts96`, `in_ts64` and `in_fmt` captured with a frame's start beat appear on `out_req`, `out_fp`, `out_ts96`, `out_ts64` and `out_fmt` while that frame's start beat is presented.
- R4: A frame counts as PTP only in these cases. Bytes 12-13 are 0x88F7, giving header start H=14. Bytes 12-13 are 0x0800, byte 14 is 0x45, byte 23 is 17 and bytes 36-37 are 319 or 320, giving H=42. Bytes 12-13 are 0x86DD, byte 20 is 17 and bytes 56-57 are 319 or 320, giving H=62. Multi-byte fields are most significant byte first.
- R5: A frame of kind R4 counts as PTP only if its length is at least H+16, plus 4 more bytes when `in_crc` was high on its start beat.
- R6: For a PTP frame, `out_off_ts` is H+34 and `out_off_corr` is H+8.
- R7: For a PTP frame, `out_off_csum` is 40 for IPv4, 60 for IPv6 and 0 for Ethernet. `out_off_csum_fix` is 52 plus the UDP length in bytes 58-59 for IPv6, and 0 otherwise.
- R8: The message type is the low nibble of byte H, and types 0 to 7 are event messages. For a PTP event frame, `out_ts_insert` equals the captured request and `out_res_update` equals its inverse. Both are 0 for non-event frames.
- R9: `out_csum_zero` is high only for IPv4 PTP event frames. `out_csum_fix` is high only for IPv6 PTP event frames.
- R10: All flags and offsets are 0 unless a start beat of a PTP frame is being presented. Non-PTP frames give all zeros.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.
- R12: A frame's start beat is not presented until the pipeline holds either its end beat or a full header window behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8*BPB | Input beat data |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Input start of frame |
| in_eop | input | 1 | Input end of frame |
| in_empty | input | EW | Unused bytes in the end beat (ignored when BPB is 1) |
| in_err | input | 1 | Input error marker |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_req | input | 1 | Timestamp request, read with the start beat |
| in_fp | input | FPW | Request fingerprint |
| in_ts96 | input | 96 | 96-bit ingress timestamp |
| in_ts64 | input | 64 | 64-bit ingress timestamp |
| in_fmt | input | 1 | Timestamp format selector |
| in_crc | input | 1 | Frame carries a trailing 4-byte CRC |
| out_data | output | 8*BPB | Output beat data |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Output start of frame |
| out_eop | output | 1 | Output end of frame |
| out_empty | output | EW | Output empty count |
| out_err | output | 1 | Output error marker |
| out_ready | input | 1 | Downstream accepts a beat |
| out_req | output | 1 | Delayed timestamp request |
| out_fp | output | FPW | Delayed fingerprint |
| out_ts96 | output | 96 | Delayed 96-bit timestamp |
| out_ts64 | output | 64 | Delayed 64-bit timestamp |
| out_fmt | output | 1 | Delayed format selector |
| out_ts_insert | output | 1 | Egress timestamp to be written |
| out_res_update | output | 1 | Residence time to be added to correction |
| out_csum_zero | output | 1 | UDP checksum to be cleared |
| out_csum_fix | output | 1 | UDP checksum to be compensated |
| out_off_ts | output | 16 | Byte offset of the timestamp field |
| out_off_corr | output | 16 | Byte offset of the correction field |
| out_off_csum | output | 16 | Byte offset of the UDP checksum |
| out_off_csum_fix | output | 16 | Byte offset of the checksum compensation bytes |

## Verification
The classification results and delayed sideband come out combinationally in the same cycle as the frame's start beat. Each beat is due out on the first edge where `out_valid` and `out_ready` are both high, which is at least the pipeline depth later than its acceptance. The bench does not predict a fixed latency. It samples one time unit before each rising edge and compares each transfer with a queue of expected beats. It checks results whenever a start beat is shown, including stalled cycles, and compares held beats one cycle after a refused transfer. The check for R12 looks for the absence of output while a lone start beat sits in the pipeline for more cycles than the pipeline depth.

// File: rtl/ptp_frame_classifier.sv
module ptp_frame_classifier #(
  parameter int BPB = 8,
  parameter int FPW = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [8*BPB-1:0]                       in_data,
  input  logic                                   in_valid,
  input  logic                                   in_sop,
  input  logic                                   in_eop,
  input  logic [((BPB>1)?$clog2(BPB):1)-1:0]     in_empty,
  input  logic                                   in_err,
  output logic                                   in_ready,
  input  logic                                   in_req,
  input  logic [FPW-1:0]                         in_fp,
  input  logic [95:0]                            in_ts96,
  input  logic [63:0]                            in_ts64,
  input  logic                                   in_fmt,
  input  logic                                   in_crc,
  output logic [8*BPB-1:0]                       out_data,
  output logic                                   out_valid,
  output logic                                   out_sop,
  output logic                                   out_eop,
  output logic [((BPB>1)?$clog2(BPB):1)-1:0]     out_empty,
  output logic                                   out_err,
  input  logic                                   out_ready,
  output logic                                   out_req,
  output logic [FPW-1:0]                         out_fp,
  output logic [95:0]                            out_ts96,
  output logic [63:0]                            out_ts64,
  output logic                                   out_fmt,
  output logic                                   out_ts_insert,
  output logic                                   out_res_update,
  output logic                                   out_csum_zero,
  output logic                                   out_csum_fix,
  output logic [15:0]                            out_off_ts,
  output logic [15:0]                            out_off_corr,
  output logic [15:0]                            out_off_csum,
  output logic [15:0]                            out_off_csum_fix
);
  localparam int DW    = 8*BPB;
  localparam int EW    = (BPB > 1) ? $clog2(BPB) : 1;
  localparam int NEED  = 62 + 16 + 4;
  localparam int D     = (NEED + BPB - 1) / BPB;
  localparam int WB    = D * BPB;
  localparam int P_CRC = 0;
  localparam int P_FMT = 1;
  localparam int P_T64 = 2;
  localparam int P_T96 = P_T64 + 64;
  localparam int P_FP  = P_T96 + 96;
  localparam int P_REQ = P_FP + FPW;
  localparam int P_ERR = P_REQ + 1;
  localparam int P_EMP = P_ERR + 1;
  localparam int P_EOP = P_EMP + EW;
  localparam int P_SOP = P_EOP + 1;
  localparam int P_DAT = P_SOP + 1;
  localparam int RW    = P_DAT + DW;

  logic [RW-1:0] rq [D];
  logic [D-1:0]  v;
  logic [D-1:0]  free;
  logic [RW-1:0] in_rec;
  logic [7:0]    wb [WB];
  logic          hdr_ok;
  logic [15:0]   avail;

  assign in_rec = {in_data, in_sop, in_eop, in_empty, in_err,
                   in_req, in_fp, in_ts96, in_ts64, in_fmt, in_crc};

  always_comb begin
    free[0] = !v[0] || (out_valid && out_ready);
    for (int k = 1; k < D; k++) free[k] = !v[k] || free[k-1];
  end
  assign in_ready = free[D-1];

  always_ff @(posedge clk) begin
    if (rst) v <= '0;
    else begin
      for (int k = 0; k < D-1; k++) if (free[k]) v[k] <= v[k+1];
      if (free[D-1]) v[D-1] <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < D-1; k++) if (free[k]) rq[k] <= rq[k+1];
    if (free[D-1]) rq[D-1] <= in_rec;
  end

  always_comb begin
    for (int k = 0; k < D; k++)
      for (int b = 0; b < BPB; b++)
        wb[k*BPB+b] = rq[k][P_DAT + DW - 8 - 8*b +: 8];
  end

  always_comb begin
    logic stop;
    stop   = 1'b0;
    hdr_ok = 1'b0;
    avail  = 16'(WB);
    for (int k = 0; k < D; k++) begin
      if (!stop) begin
        if (!v[k]) stop = 1'b1;
        else if (rq[k][P_EOP]) begin
          hdr_ok = 1'b1;
          avail  = 16'(k*BPB + BPB) - ((BPB > 1) ? 16'(rq[k][P_EMP +: EW]) : 16'd0);
          stop   = 1'b1;
        end else if (k == D-1) hdr_ok = 1'b1;
      end
    end
  end

  assign out_valid = v[0] && (!rq[0][P_SOP] || hdr_ok);
  assign out_data  = rq[0][P_DAT +: DW];
  assign out_sop   = rq[0][P_SOP];
  assign out_eop   = rq[0][P_EOP];
  assign out_empty = rq[0][P_EMP +: EW];
  assign out_err   = rq[0][P_ERR];
  assign out_req   = rq[0][P_REQ];
  assign out_fp    = rq[0][P_FP +: FPW];
  assign out_ts96  = rq[0][P_T96 +: 96];
  assign out_ts64  = rq[0][P_T64 +: 64];
  assign out_fmt   = rq[0][P_FMT];

  function automatic logic port_hit(input logic [7:0] hi, input logic [7:0] lo);
    return ({hi, lo} == 16'd319) || ({hi, lo} == 16'd320);
  endfunction

  logic [15:0] etype, hdr;
  logic        is_l2, is_v4, is_v6, long_ok, lead, ptp, ev;
  logic [3:0]  mtype;

  assign etype = {wb[12], wb[13]};
  assign is_l2 = etype == 16'h88F7;
  assign is_v4 = etype == 16'h0800 && wb[14] == 8'h45 && wb[23] == 8'd17 && port_hit(wb[36], wb[37]);
  assign is_v6 = etype == 16'h86DD && wb[20] == 8'd17 && port_hit(wb[56], wb[57]);
  assign hdr   = is_l2 ? 16'd14 : is_v4 ? 16'd42 : 16'd62;
  assign mtype = is_l2 ? wb[14][3:0] : is_v4 ? wb[42][3:0] : wb[62][3:0];
  assign long_ok = avail >= hdr + 16'd16 + (rq[0][P_CRC] ? 16'd4 : 16'd0);
  assign lead  = out_valid && out_sop;
  assign ptp   = lead && (is_l2 || is_v4 || is_v6) && long_ok;
  assign ev    = mtype < 4'd8;

  assign out_ts_insert    = ptp && ev && out_req;
  assign out_res_update   = ptp && ev && !out_req;
  assign out_csum_zero    = ptp && ev && is_v4;
  assign out_csum_fix     = ptp && ev && is_v6;
  assign out_off_ts       = ptp ? hdr + 16'd34 : 16'd0;
  assign out_off_corr     = ptp ? hdr + 16'd8 : 16'd0;
  assign out_off_csum     = !ptp ? 16'd0 : is_v4 ? 16'd40 : is_v6 ? 16'd60 : 16'd0;
  assign out_off_csum_fix = (ptp && is_v6) ? 16'd52 + {wb[58], wb[59]} : 16'd0;

  a_r2_hold_beat: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));
  a_r8_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_ts_insert, out_res_update}));
  a_r10_flags_on_lead: assert property (@(posedge clk) disable iff (rst)
    (out_ts_insert || out_res_update || out_csum_zero || out_csum_fix) |-> (out_valid && out_sop));
  a_r6_field_gap: assert property (@(posedge clk) disable iff (rst)
    out_res_update |-> out_off_ts == out_off_corr + 16'd26);
  a_r9_csum_excl: assert property (@(posedge clk) disable iff (rst)
    !(out_csum_zero && out_csum_fix));
  a_r11_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/tb_ptp_frame_classifier.sv
module tb_ptp_frame_classifier;
  localparam int PER = 10;
  localparam int HALF = PER / 2;
  localparam int BPB = 8;
  localparam int FPW = 4;
  localparam int EW = 3;
  localparam int DEPTH = 11;

  logic clk = 1'b0, rst = 1'b1;
  logic [63:0] in_data = '0, out_data;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0, in_ready;
  logic [EW-1:0] in_empty = '0, out_empty;
  logic in_req = 1'b0, in_fmt = 1'b0, in_crc = 1'b0;
  logic [FPW-1:0] in_fp = '0, out_fp;
  logic [95:0] in_ts96 = '0, out_ts96;
  logic [63:0] in_ts64 = '0, out_ts64;
  logic out_valid, out_sop, out_eop, out_err, out_ready = 1'b0;
  logic out_req, out_fmt, out_ts_insert, out_res_update, out_csum_zero, out_csum_fix;
  logic [15:0] out_off_ts, out_off_corr, out_off_csum, out_off_csum_fix;

  ptp_frame_classifier #(.BPB(BPB), .FPW(FPW)) dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_empty(in_empty), .in_err(in_err), .in_ready(in_ready),
    .in_req(in_req), .in_fp(in_fp), .in_ts96(in_ts96), .in_ts64(in_ts64),
    .in_fmt(in_fmt), .in_crc(in_crc), .out_data(out_data), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty), .out_err(out_err),
    .out_ready(out_ready), .out_req(out_req), .out_fp(out_fp), .out_ts96(out_ts96),
    .out_ts64(out_ts64), .out_fmt(out_fmt), .out_ts_insert(out_ts_insert),
    .out_res_update(out_res_update), .out_csum_zero(out_csum_zero),
    .out_csum_fix(out_csum_fix), .out_off_ts(out_off_ts), .out_off_corr(out_off_corr),
    .out_off_csum(out_off_csum), .out_off_csum_fix(out_off_csum_fix));

  always #(HALF) clk = ~clk;

  typedef struct packed {
    logic [63:0] d; logic sop; logic eop; logic [EW-1:0] emp; logic err;
  } beat_t;
  typedef struct packed {
    logic ins; logic upd; logic cz; logic cf;
    logic [15:0] ots; logic [15:0] oc; logic [15:0] ocs; logic [15:0] ocf;
    logic req; logic [FPW-1:0] fp; logic [95:0] t96; logic [63:0] t64; logic fmt;
  } pk_t;

  beat_t exp_beats[$];
  pk_t   exp_pk[$];
  int    exp_cat[$];
  int nchk = 0, nfail = 0, cyc = 0, bp_seen = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk)
    out_ready <= !((cyc % 7) == 3) && !(((cyc % 150) >= 100) && ((cyc % 150) < 130));

  initial begin
    beat_t held;
    bit stalled = 1'b0;
    forever begin
      @(negedge clk);
      #(HALF-1);
      if (!rst) begin
        beat_t obs;
        obs = {out_data, out_sop, out_eop, out_empty, out_err};
        if (!in_ready) bp_seen++;
        if (stalled) begin
          check(out_valid, "R2", "valid held", 256'(out_valid), 256'(1));
          check(obs == held, "R2", "beat held", 256'(obs), 256'(held));
        end
        if (out_valid && out_sop) begin
          if (exp_pk.size() == 0) check(1'b0, "R1", "unexpected frame", 256'(1), 256'(0));
          else begin
            pk_t e;
            pk_t a;
            string t;
            e = exp_pk[0];
            a = {out_ts_insert, out_res_update, out_csum_zero, out_csum_fix,
                 out_off_ts, out_off_corr, out_off_csum, out_off_csum_fix,
                 out_req, out_fp, out_ts96, out_ts64, out_fmt};
            t = (exp_cat[0] == 0) ? "R4" : (exp_cat[0] == 1) ? "R5" : "R8";
            check({a.ins, a.upd} == {e.ins, e.upd}, t, "insert/update", 256'({a.ins, a.upd}), 256'({e.ins, e.upd}));
            check({a.cz, a.cf} == {e.cz, e.cf}, "R9", "csum flags", 256'({a.cz, a.cf}), 256'({e.cz, e.cf}));
            check({a.ots, a.oc} == {e.ots, e.oc}, "R6", "ts/corr offsets", 256'({a.ots, a.oc}), 256'({e.ots, e.oc}));
            check({a.ocs, a.ocf} == {e.ocs, e.ocf}, "R7", "csum offsets", 256'({a.ocs, a.ocf}), 256'({e.ocs, e.ocf}));
            check({a.req, a.fp, a.t96, a.t64, a.fmt} == {e.req, e.fp, e.t96, e.t64, e.fmt}, "R3", "sideband",
                  256'({a.req, a.fp, a.t96, a.t64, a.fmt}), 256'({e.req, e.fp, e.t96, e.t64, e.fmt}));
            if (out_ready) begin
              void'(exp_pk.pop_front());
              void'(exp_cat.pop_front());
            end
          end
        end else begin
          check({out_ts_insert, out_res_update, out_csum_zero, out_csum_fix} == 4'b0 &&
                {out_off_ts, out_off_corr, out_off_csum, out_off_csum_fix} == 64'b0,
                "R10", "quiet outside lead beat",
                256'({out_ts_insert, out_res_update, out_csum_zero, out_csum_fix, out_off_ts, out_off_corr, out_off_csum, out_off_csum_fix}), 256'(0));
        end
        if (out_valid && out_ready) begin
          if (exp_beats.size() == 0) check(1'b0, "R1", "extra beat", 256'(obs), 256'(0));
          else begin
            beat_t eb;
            eb = exp_beats.pop_front();
            check(obs == eb, "R1", "beat", 256'(obs), 256'(eb));
          end
        end
        stalled = out_valid && !out_ready;
        held = obs;
      end
    end
  end

  task automatic drive_beat(input beat_t b, input bit rq, input logic [FPW-1:0] fp,
                            input logic [95:0] t96, input logic [63:0] t64, input bit fm, input bit cr);
    @(negedge clk);
    in_valid = 1'b1; in_data = b.d; in_sop = b.sop; in_eop = b.eop; in_empty = b.emp; in_err = b.err;
    in_req = rq; in_fp = fp; in_ts96 = t96; in_ts64 = t64; in_fmt = fm; in_crc = cr;
    forever begin
      #(HALF-1);
      if (in_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic send_frame(input int kind, input int mt, input bit rq, input bit cr,
                            input int len, input int idx, input int gap1);
    logic [7:0] by [256];
    int h, nb, ulen;
    bit ptp;
    pk_t e;
    logic [95:0] t96;
    logic [63:0] t64;
    for (int k = 0; k < 256; k++) by[k] = 8'(idx*13 + k*7 + 1);
    ulen = 40 + idx % 50;
    case (kind)
      0: begin {by[12], by[13]} = 16'h88F7; by[14] = {4'(idx), 4'(mt)}; end
      1, 4: begin
        {by[12], by[13]} = 16'h0800; by[14] = 8'h45; by[23] = 8'd17;
        {by[36], by[37]} = (kind == 4) ? 16'd1234 : (idx[0] ? 16'd320 : 16'd319);
        by[42] = {4'(idx), 4'(mt)};
      end
      2, 5: begin
        {by[12], by[13]} = 16'h86DD; by[20] = (kind == 5) ? 8'd6 : 8'd17;
        {by[56], by[57]} = idx[0] ? 16'd319 : 16'd320;
        {by[58], by[59]} = 16'(ulen); by[62] = {4'(idx), 4'(mt)};
      end
      default: begin {by[12], by[13]} = 16'h0806; end
    endcase
    h = (kind == 0) ? 14 : (kind == 1) ? 42 : 62;
    ptp = (kind < 3) && (len >= h + 16 + (cr ? 4 : 0));
    e.ins = ptp && mt < 8 && rq;
    e.upd = ptp && mt < 8 && !rq;
    e.cz  = ptp && mt < 8 && kind == 1;
    e.cf  = ptp && mt < 8 && kind == 2;
    e.ots = ptp ? 16'(h + 34) : 16'd0;
    e.oc  = ptp ? 16'(h + 8) : 16'd0;
    e.ocs = !ptp ? 16'd0 : (kind == 1) ? 16'd40 : (kind == 2) ? 16'd60 : 16'd0;
    e.ocf = (ptp && kind == 2) ? 16'(52 + ulen) : 16'd0;
    t96 = {32'(idx), 64'h0123456789ABCDEF ^ 64'(idx)};
    t64 = {32'(idx*3), 32'hCAFEF00D};
    e.req = rq; e.fp = FPW'(idx); e.t96 = t96; e.t64 = t64; e.fmt = idx[1];
    exp_pk.push_back(e);
    exp_cat.push_back(kind >= 3 ? 0 : (!ptp ? 1 : 2));
    nb = (len + BPB - 1) / BPB;
    for (int b = 0; b < nb; b++) begin
      beat_t bt;
      for (int j = 0; j < BPB; j++)
        bt.d[63 - 8*j -: 8] = (b*BPB + j < len) ? by[b*BPB + j] : 8'h00;
      bt.sop = (b == 0);
      bt.eop = (b == nb - 1);
      bt.emp = bt.eop ? EW'(nb*BPB - len) : '0;
      bt.err = bt.eop && (idx % 5 == 0);
      exp_beats.push_back(bt);
      drive_beat(bt, rq, FPW'(idx), t96, t64, idx[1], cr);
      if (b == 0 && gap1 > 0) begin
        idle(gap1);
        #(HALF-1);
        check(!out_valid, "R12", "lead beat held for header", 256'(out_valid), 256'(0));
      end else if ((idx + b) % 5 == 4) idle(1);
    end
    idle(idx % 3 + 1);
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_beats.size() != 0) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(exp_beats.size() == 0, "R1", "all beats delivered", 256'(exp_beats.size()), 256'(0));
  endtask

  initial begin
    int idx = 0;
    repeat (4) @(negedge clk);
    #(HALF-1);
    check(!out_valid, "R11", "out_valid in reset", 256'(out_valid), 256'(0));
    check(in_ready, "R11", "in_ready in reset", 256'(in_ready), 256'(1));
    @(negedge clk);
    rst = 1'b0;
    #(HALF-1);
    check(!out_valid, "R11", "out_valid after reset", 256'(out_valid), 256'(0));
    check(in_ready, "R11", "in_ready after reset", 256'(in_ready), 256'(1));
    for (int kind = 0; kind < 6; kind++)
      for (int mt = 0; mt < 16; mt++)
        for (int rq = 0; rq < 2; rq++)
          for (int lv = 0; lv < 3; lv++) begin
            int h, need, len;
            bit cr;
            idx++;
            cr = idx[0];
            h = (kind == 0 || kind == 3) ? 14 : (kind == 1 || kind == 4) ? 42 : 62;
            need = h + 16 + (cr ? 4 : 0);
            len = (lv == 0) ? need : (lv == 1) ? need - 1 : need + 37;
            send_frame(kind, mt, rq[0], cr, len, idx, 0);
          end
    for (int l = 1; l <= 16; l++) begin
      idx++;
      send_frame(3, 0, 1'b0, 1'b0, l, idx, 0);
    end
    drain();
    idx++;
    send_frame(0, 2, 1'b1, 1'b0, 96, idx, DEPTH + 20);
    drain();
    check(exp_pk.size() == 0, "R1", "all frames delivered", 256'(exp_pk.size()), 256'(0));
    check(bp_seen > 0, "R2", "input backpressure seen", 256'(bp_seen), 256'(1));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule